// File: doc/BRIEF.md
# Page-Addressed Monochrome Display Controller

This block sits behind a word-wide register port and owns the frame store of a 128 by 64 one-bit display. The frame store is organised as eight pages, and each page holds 128 column bytes. Software first writes a mode word that selects either command or data handling. Page-select bytes then choose the page, and a stream of data bytes fills the columns of that page from left to right.

A separate pixel port takes an (x, y) coordinate and returns a 24-bit RGB colour one clock later. Lit pixels take a fixed pale-blue tint and unlit pixels are black. Every channel is scaled by a 3-bit brightness value, and each bit of that value arrives on its own input line. A display refresh engine walks this port to produce its picture.

Top module: `mono_lcd_ctrl`

## Requirements
- R1: A write to the mode register at offset 0x1AC selects data mode only for the exact value 0x00100011 and command mode only for the exact value 0x00104011. Any other value selects an invalid mode, which is also the mode after reset. In the invalid mode, writes to the data register leave the frame store and the column position unchanged.
- R2: A write to the instruction register at offset 0x1BC with a value in the range 0xB0 to 0xB7 selects page (value - 0xB0) and returns the column position to 0. Any other value leaves the page and the column position unchanged.
- R3: In command mode, a write to the data register at offset 0x1C0 is treated the same way as an instruction-register write, and the frame store is not written.
- R4: In data mode, a write to the data register stores bits 7:0 of the written word at byte address page*128 + column. The column then advances by one.
- R5: The column position wraps from 127 to 0 and stays on the same page.
- R6: Pixel (x, y) is bit (y mod 8) of the byte at address x + (y/8)*128.
- R7: A lit pixel returns 0xE0E0FF (red in bits 23:16, blue in bits 7:0) and an unlit pixel returns 0. The colour appears on the clock edge after the coordinate is presented.
- R8: Each colour channel is channel*b/7 using integer division, where b is the brightness. This gives 0 for b = 0 and the unscaled channel for b = 7.
- R9: Brightness is sampled from its three input lines on every clock, one bit per line, and resets to 7.
- R10: The interrupt-control register at offset 0x180 holds a 32-bit value that can be written and read back. A read of any other offset returns 0. Read data appears on the clock edge after the read is requested, and rdata is 0 in any cycle that follows no read.
- R11: If a data write and a pixel read address the same byte in the same cycle, the pixel port returns the byte as it was before the write. The same rule applies to a write and a read of the interrupt-control register in one cycle, which returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, one cycle after rd_en |
| pix_x | input | 7 | Pixel column |
| pix_y | input | 6 | Pixel row |
| bright_lvl | input | 3 | Brightness lines, one bit each |
| pix_rgb | output | 24 | Pixel colour, one cycle after the coordinate |

## Verification
The properties assume that the register strobes and the address are valid on every clock once reset is released. They also assume that the brightness lines are driven to known levels, because the colour checks relate the sampled brightness to pix_rgb. The bench drives all inputs from the negative clock edge to known values and never leaves any of them undriven. Before it compares any pixel colour, it writes each byte of the frame store through the data register, so every pixel compared comes from a byte the bench model knows.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam logic [11:0] OFF_IRQCTL = 12'h180;
  localparam logic [11:0] OFF_MODE   = 12'h1AC;
  localparam logic [11:0] OFF_INSTR  = 12'h1BC;
  localparam logic [11:0] OFF_DATA   = 12'h1C0;

  localparam logic [31:0] MODE_WORD_DATA = 32'h0010_0011;
  localparam logic [31:0] MODE_WORD_CMD  = 32'h0010_4011;
  localparam logic [31:0] PAGE_CMD_BASE  = 32'h0000_00B0;

  localparam logic [23:0] LIT_TINT   = 24'hE0E0FF;
  localparam logic [2:0]  BRIGHT_MAX = 3'd7;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DATA = 2'd1,
    MODE_CMD  = 2'd2
  } lcd_mode_e;

  function automatic logic [7:0] scale_chan(input logic [7:0] c, input logic [2:0] b);
    logic [10:0] prod;
    prod = {3'b0, c} * {8'b0, b};
    return 8'(prod / 11'd7);
  endfunction
endpackage

// File: rtl/lcd_regif.sv
module lcd_regif
  import lcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COLS   = 128,
  parameter int PAGES  = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int PG_W  = $clog2(PAGES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic                  vram_we,
  output logic [PG_W+COL_W-1:0] vram_waddr,
  output logic [7:0]            vram_wdata,
  output lcd_mode_e             mode_q,
  output logic [PG_W-1:0]       page_q,
  output logic [COL_W-1:0]      col_q
);
  logic [31:0] irqctl_q;
  logic [31:0] page_rel;
  logic        page_hit;
  logic        hit_irq, hit_mode, hit_instr, hit_data;
  logic        set_page;

  assign hit_irq   = (addr == ADDR_W'(OFF_IRQCTL));
  assign hit_mode  = (addr == ADDR_W'(OFF_MODE));
  assign hit_instr = (addr == ADDR_W'(OFF_INSTR));
  assign hit_data  = (addr == ADDR_W'(OFF_DATA));

  assign page_rel = wdata - PAGE_CMD_BASE;
  assign page_hit = (wdata >= PAGE_CMD_BASE) && (page_rel < 32'(PAGES));

  assign set_page = wr_en && page_hit &&
                    (hit_instr || (hit_data && mode_q == MODE_CMD));

  assign vram_we    = wr_en && hit_data && (mode_q == MODE_DATA);
  assign vram_waddr = {page_q, col_q};
  assign vram_wdata = wdata[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_OFF;
      page_q   <= '0;
      col_q    <= '0;
      irqctl_q <= '0;
      rdata    <= '0;
    end else begin
      rdata <= (rd_en && hit_irq) ? irqctl_q : '0;
      if (wr_en && hit_irq) irqctl_q <= wdata;
      if (wr_en && hit_mode) begin
        if (wdata == MODE_WORD_DATA)     mode_q <= MODE_DATA;
        else if (wdata == MODE_WORD_CMD) mode_q <= MODE_CMD;
        else                             mode_q <= MODE_OFF;
      end
      if (set_page) begin
        page_q <= page_rel[PG_W-1:0];
        col_q  <= '0;
      end else if (vram_we) begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_vram.sv
module lcd_vram #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcd_pixel.sv
module lcd_pixel
  import lcd_pkg::*;
#(
  parameter int COLS    = 128,
  parameter int PAGES   = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int PG_W   = $clog2(PAGES),
  localparam int ROW_W  = PG_W + 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [COL_W-1:0]      pix_x,
  input  logic [ROW_W-1:0]      pix_y,
  input  logic [2:0]            bright_lvl,
  output logic [PG_W+COL_W-1:0] raddr,
  input  logic [7:0]            rbyte,
  output logic [2:0]            bright_q,
  output logic [23:0]           pix_rgb
);
  logic [2:0] bitsel_q;
  logic       lit;

  assign raddr = {pix_y[ROW_W-1:3], pix_x};

  always_ff @(posedge clk) begin
    if (rst) begin
      bitsel_q <= '0;
      bright_q <= BRIGHT_MAX;
    end else begin
      bitsel_q <= pix_y[2:0];
      bright_q <= bright_lvl;
    end
  end

  assign lit = rbyte[bitsel_q];

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    assign pix_rgb[ch*8 +: 8] = lit ? scale_chan(LIT_TINT[ch*8 +: 8], bright_q) : 8'h00;
  end
endmodule

// File: rtl/mono_lcd_ctrl.sv
module mono_lcd_ctrl
  import lcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COLS   = 128,
  parameter int PAGES  = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int PG_W  = $clog2(PAGES),
  localparam int ROW_W = PG_W + 3,
  localparam int DEPTH = COLS * PAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [COL_W-1:0]  pix_x,
  input  logic [ROW_W-1:0]  pix_y,
  input  logic [2:0]        bright_lvl,
  output logic [23:0]       pix_rgb
);
  logic                  vram_we;
  logic [PG_W+COL_W-1:0] vram_waddr;
  logic [7:0]            vram_wdata;
  logic [PG_W+COL_W-1:0] vram_raddr;
  logic [7:0]            vram_rbyte;
  lcd_mode_e             mode_q;
  logic [PG_W-1:0]       page_q;
  logic [COL_W-1:0]      col_q;
  logic [2:0]            bright_now;

  lcd_regif #(.ADDR_W(ADDR_W), .COLS(COLS), .PAGES(PAGES)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .vram_we(vram_we), .vram_waddr(vram_waddr),
    .vram_wdata(vram_wdata), .mode_q(mode_q), .page_q(page_q), .col_q(col_q)
  );

  lcd_vram #(.DEPTH(DEPTH)) u_vram (
    .clk(clk), .rst(rst), .we(vram_we), .waddr(vram_waddr), .wdata(vram_wdata),
    .raddr(vram_raddr), .rdata(vram_rbyte)
  );

  lcd_pixel #(.COLS(COLS), .PAGES(PAGES)) u_pixel (
    .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .bright_lvl(bright_lvl),
    .raddr(vram_raddr), .rbyte(vram_rbyte), .bright_q(bright_now), .pix_rgb(pix_rgb)
  );
endmodule

// File: rtl/lcd_ctrl_chk.sv
module lcd_ctrl_chk
  import lcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 7,
  parameter int PG_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [23:0]       pix_rgb,
  input lcd_mode_e         mode_q,
  input logic [PG_W-1:0]   page_q,
  input logic [COL_W-1:0]  col_q,
  input logic [2:0]        bright_now
);
  assert_bad_mode_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_MODE) && wdata != MODE_WORD_DATA && wdata != MODE_WORD_CMD)
    |=> mode_q == MODE_OFF);

  assert_page_select_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_INSTR) && wdata >= 32'hB0 && wdata < 32'hB0 + 32'(1 << PG_W))
    |=> (page_q == $past(wdata[PG_W-1:0]) && col_q == '0));

  assert_col_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_DATA) && mode_q == MODE_DATA)
    |=> (col_q == $past(col_q) + COL_W'(1) && $stable(page_q)));

  assert_invalid_data_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_DATA) && mode_q == MODE_OFF)
    |=> ($stable(col_q) && $stable(page_q)));

  assert_dark_R8: assert property (@(posedge clk) disable iff (rst)
    (bright_now == 3'd0) |-> pix_rgb == 24'h0);

  assert_tint_R7: assert property (@(posedge clk) disable iff (rst)
    (bright_now == BRIGHT_MAX) |-> (pix_rgb == 24'h0 || pix_rgb == LIT_TINT));

  assert_other_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ADDR_W'(OFF_IRQCTL)) |=> rdata == 32'h0);
endmodule

bind mono_lcd_ctrl lcd_ctrl_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W), .PG_W(PG_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pix_rgb(pix_rgb), .mode_q(mode_q), .page_q(page_q), .col_q(col_q),
  .bright_now(bright_now)
);

// File: tb/tb_mono_lcd_ctrl.sv
module tb_mono_lcd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  pix_x = '0;
  logic [5:0]  pix_y = '0;
  logic [2:0]  bright_lvl = 3'd7;
  logic [23:0] pix_rgb;

  mono_lcd_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pix_x(pix_x), .pix_y(pix_y), .bright_lvl(bright_lvl), .pix_rgb(pix_rgb)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  int m_vram [1024];
  bit m_known [1024];
  int m_mode = 0;
  int m_page = 0, m_col = 0;
  int unsigned m_irq = 0;
  int cur_x = 0, cur_y = 0, cur_b = 7;

  function automatic int sc(int c, int b);
    return (c * b) / 7;
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(bit we, bit re, logic [11:0] a, logic [31:0] d, string tag);
    int idx, byt, pg;
    logic [31:0] exp_rd;
    logic [23:0] exp_pix;
    bit chk_pix;
    wr_en = we; rd_en = re; addr = a; wdata = d;
    pix_x = 7'(cur_x); pix_y = 6'(cur_y); bright_lvl = 3'(cur_b);
    @(posedge clk);
    idx = cur_x + (cur_y / 8) * 128;
    exp_rd = (re && a == 12'h180) ? m_irq : 32'h0;
    chk_pix = m_known[idx];
    byt = m_vram[idx];
    if (((byt >> (cur_y % 8)) & 1) != 0)
      exp_pix = {8'(sc(224, cur_b)), 8'(sc(224, cur_b)), 8'(sc(255, cur_b))};
    else
      exp_pix = 24'h0;
    if (we) begin
      pg = (d >= 32'hB0 && d <= 32'hB7) ? int'(d - 32'hB0) : -1;
      if (a == 12'h180) m_irq = d;
      if (a == 12'h1AC) m_mode = (d == 32'h0010_0011) ? 1 : (d == 32'h0010_4011) ? 2 : 0;
      if ((a == 12'h1BC || (a == 12'h1C0 && m_mode == 2)) && pg >= 0) begin
        m_page = pg; m_col = 0;
      end else if (a == 12'h1C0 && m_mode == 1) begin
        m_vram[m_page * 128 + m_col] = int'(d[7:0]);
        m_known[m_page * 128 + m_col] = 1;
        m_col = (m_col + 1) % 128;
      end
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check(tag, "rdata", rdata, exp_rd);
    if (chk_pix) check(tag, "pix_rgb", {8'h0, pix_rgb}, {8'h0, exp_pix});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) begin m_vram[i] = 0; m_known[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // reset state: colour idle, read data zero, irq control zero (R9, R10)
    check("R10", "rdata after reset", rdata, 32'h0);
    check("R7", "pix_rgb after reset", {8'h0, pix_rgb}, 32'h0);
    step(0, 1, 12'h180, 0, "R10");
    // invalid mode after reset: data writes ignored (R1)
    step(1, 0, 12'h1C0, 32'hFF, "R1");
    // data mode, fill every page (R4, R2)
    step(1, 0, 12'h1AC, 32'h0010_0011, "R1");
    for (int p = 0; p < 8; p++) begin
      step(1, 0, 12'h1BC, 32'hB0 + p, "R2");
      for (int c = 0; c < 128; c++) begin
        cur_x = (c * 5) % 128; cur_y = (c * 3 + p) % 64;
        step(1, 0, 12'h1C0, 32'h3300 | (((p * 37 + c * 13) ^ 8'h5A) & 8'hFF), "R4");
      end
    end
    // wrap: page 7 column back at 0 (R5)
    step(1, 0, 12'h1C0, 32'hFF, "R5");
    step(1, 0, 12'h1C0, 32'h81, "R5");
    cur_x = 0; cur_y = 56; step(0, 0, 0, 0, "R5");
    cur_x = 1; cur_y = 63; step(0, 0, 0, 0, "R5");
    // out-of-range page commands ignored: next byte lands at column 2 (R2)
    step(1, 0, 12'h1BC, 32'hB8, "R2");
    step(1, 0, 12'h1BC, 32'hAF, "R2");
    step(1, 0, 12'h1BC, 32'h1B3, "R2");
    step(1, 0, 12'h1C0, 32'hFF, "R2");
    cur_x = 2; cur_y = 60; step(0, 0, 0, 0, "R2");
    // command mode: data register selects page, no store (R3)
    step(1, 0, 12'h1AC, 32'h0010_4011, "R3");
    step(1, 0, 12'h1C0, 32'hB3, "R3");
    step(1, 0, 12'h1C0, 32'h00, "R3");
    cur_x = 0; cur_y = 24; step(0, 0, 0, 0, "R3");
    step(1, 0, 12'h1AC, 32'h0010_0011, "R3");
    step(1, 0, 12'h1C0, 32'hA5, "R3");
    for (int y = 24; y < 32; y++) begin cur_y = y; step(0, 0, 0, 0, "R6"); end
    // near-miss mode word gives invalid mode, data ignored (R1)
    step(1, 0, 12'h1AC, 32'h0010_0010, "R1");
    step(1, 0, 12'h1C0, 32'h00, "R1");
    cur_x = 1; cur_y = 24; step(0, 0, 0, 0, "R1");
    step(1, 0, 12'h1AC, 32'h0010_0011, "R1");
    step(1, 0, 12'h1C0, 32'h0F, "R1");
    cur_x = 1; step(0, 0, 0, 0, "R1");
    // same-cycle write and pixel read of one byte return the old byte (R11)
    cur_x = 2; cur_y = 24;
    step(1, 0, 12'h1C0, 32'h00, "R11");
    step(0, 0, 0, 0, "R11");
    // brightness sweep over all levels (R8, R9)
    step(1, 0, 12'h1BC, 32'hB0, "R8");
    step(1, 0, 12'h1C0, 32'hFF, "R8");
    for (int b = 0; b < 8; b++) begin
      cur_b = b; cur_x = 0; cur_y = b;
      step(0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, "R9");
    end
    cur_b = 7;
    // interrupt-control register, other reads zero (R10, R11)
    step(1, 0, 12'h180, 32'hDEAD_BEEF, "R10");
    step(0, 1, 12'h180, 0, "R10");
    step(1, 1, 12'h180, 32'h1234_5678, "R11");
    step(0, 1, 12'h180, 0, "R10");
    step(0, 1, 12'h1AC, 0, "R10");
    step(0, 1, 12'h1C0, 0, "R10");
    step(0, 0, 12'h180, 0, "R10");
    // scattered pixel reads (R6, R7)
    for (int i = 0; i < 300; i++) begin
      cur_x = (i * 29 + 7) % 128; cur_y = (i * 17 + 3) % 64;
      cur_b = (i % 4 == 0) ? 5 : 7;
      step(0, 0, 0, 0, "R6");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule